// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a word-wide instruction fetch port and a decoder that eats one byte at a time. It keeps up to six instruction bytes in first-in first-out order. It holds its own fetch address and asks the bus side for another word whenever at least two byte slots are free. Returned words go into the queue low byte first. The decoder sees the oldest byte on `byte_out` together with `byte_valid`. It pulses `take` to remove that byte and sets `take_first` when the byte starts a new instruction.

A branch pulses `flush` with the new target address. The queue empties, the fetch address jumps to the target, and any fetch still on the bus is thrown away when it comes back. A target with an odd address gets one byte from its first fetch: the upper half of the returned word. After that every fetch is word aligned. When the queue is empty, the first byte of an arriving word goes straight to `byte_out` in the same clock. A registered two-bit code on `q_status` reports the queue operation of the previous clock.

The fetch side is a three-state machine. Its states are IDLE (no fetch outstanding), WAIT (a fetch has been accepted and its data is due) and DROP (data is due but belongs to a flushed stream). Its transitions are:
- IDLE to WAIT when a request is accepted.
- WAIT to IDLE when data returns.
- WAIT to DROP on a flush with no data in that clock.
- DROP to IDLE when the stale data returns.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held and in the first clock after it, the queue is empty (`byte_valid` = 0), `q_status` = 00, `fetch_addr` equals the reset address parameter, and `fetch_req` is high.
- R2: `fetch_req` is high exactly when no fetch is outstanding, at least two byte slots are free, and `flush` is low.
- R3: Bytes leave in the order they arrived; from a word fetch the low byte (`fetch_data[7:0]`, lower address) leaves before the high byte (`fetch_data[15:8]`).
- R4: When the queue holds nothing and a fetch returns, `byte_valid` is high and `byte_out` shows the returned first byte in that same clock, and a `take` in that clock consumes it.
- R5: `q_status` in the clock after an operation reads: 01 for a take with `take_first` high, 11 for a take with `take_first` low, 10 for a flush, 00 otherwise.
- R6: A flush empties the queue (`byte_valid` low in the next clock); a flush and a take in the same clock report 10 and remove nothing beyond the flush.
- R7: After a flush to an odd address, the first returned word contributes only `fetch_data[15:8]` and the address advances by one. An aligned fetch contributes two bytes and the address advances by two. `fetch_addr` stays stable while a request waits to be accepted.
- R8: Data returning for a fetch that was outstanding at a flush, or that arrives in the flush clock, is discarded.
- R9: At most one fetch is outstanding (no request in the clock after an accept), and the queue never holds more than six bytes.
- R10: A `take` while `byte_valid` is low has no effect, and the status reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Request a fetch of the word holding `fetch_addr` |
| fetch_addr | output | 20 | Byte address of the next instruction byte to fetch |
| fetch_accept | input | 1 | Bus side takes the request in this clock |
| fetch_valid | input | 1 | Fetched word present on `fetch_data` |
| fetch_data | input | 16 | Fetched word, lower address in bits 7:0 |
| flush | input | 1 | Empty the queue and restart at `flush_addr` |
| flush_addr | input | 20 | Branch target byte address |
| take | input | 1 | Decoder consumes the byte on `byte_out` |
| take_first | input | 1 | The consumed byte is the first byte of an opcode |
| byte_valid | output | 1 | `byte_out` holds a byte |
| byte_out | output | 8 | Oldest instruction byte |
| q_status | output | 2 | Code for the previous clock's queue operation |

## Verification
The assertions check these properties on every clock:
- the single outstanding fetch and the free-space condition on requests;
- the six-byte bound;
- the status code after flushes, first-byte takes and idle clocks;
- an empty queue right after a flush;
- address stability while a request waits.

Byte ordering, same-clock bypass, odd-target alignment, the address step and the silent discard of stale data are shown only by the bench. Its reference model follows the byte stream and the fetch address through scenarios: filling to full, random consumption, odd and even branch targets, flushes while a fetch is outstanding, and flush together with take.

// File: rtl/prefetch_q_pkg.sv
package prefetch_q_pkg;

    typedef enum logic [1:0] {
        QS_NONE    = 2'b00,
        QS_FIRST   = 2'b01,
        QS_FLUSHED = 2'b10,
        QS_NEXT    = 2'b11
    } qstat_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_DROP = 2'd2
    } fstate_t;

endpackage

// File: rtl/prefetch_fetch_ctl.sv
module prefetch_fetch_ctl
    import prefetch_q_pkg::*;
#(
    parameter int AW = 20,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          room_ok,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          fetch_accept,
    input  logic          fetch_valid,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          land,
    output logic          land_odd
);

    fstate_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE: if (fetch_req && fetch_accept) state_nx = FS_WAIT;
            FS_WAIT: begin
                if (fetch_valid)  state_nx = FS_IDLE;
                else if (flush)   state_nx = FS_DROP;
            end
            FS_DROP: if (fetch_valid) state_nx = FS_IDLE;
            default: state_nx = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fetch_req = (state == FS_IDLE) && room_ok && !flush;
        land      = (state == FS_WAIT) && fetch_valid && !flush;
        land_odd  = fetch_addr[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    fetch_addr <= RESET_ADDR;
        else if (flush) fetch_addr <= flush_addr;
        else if (land)  fetch_addr <= fetch_addr + (land_odd ? AW'(1) : AW'(2));
    end

endmodule

// File: rtl/prefetch_ring.sv
module prefetch_ring #(
    parameter int DEPTH = 6,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [1:0]    in_cnt,
    input  logic [7:0]    in_b0,
    input  logic [7:0]    in_b1,
    input  logic          take,
    output logic          out_valid,
    output logic [7:0]    out_byte,
    output logic          popped,
    output logic [LW-1:0] level
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd, wr0, wr1;
    logic          byp, stored_pop;
    logic [1:0]    n_wr;
    logic [7:0]    w0_byte;

    function automatic logic [PW-1:0] wrap(input logic [PW:0] v);
        return (v >= (PW+1)'(DEPTH)) ? PW'(v - (PW+1)'(DEPTH)) : PW'(v);
    endfunction

    always_comb begin
        out_valid  = (level != '0) || (in_cnt != 2'd0);
        out_byte   = (level != '0) ? mem[rd] : in_b0;
        popped     = take && out_valid && !clear;
        byp        = popped && (level == '0);
        stored_pop = popped && (level != '0);
        n_wr       = byp ? in_cnt - 2'd1 : in_cnt;
        w0_byte    = byp ? in_b1 : in_b0;
        wr0        = wrap((PW+1)'(rd) + (PW+1)'(level));
        wr1        = wrap((PW+1)'(wr0) + (PW+1)'(1));
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (n_wr != 2'd0 && wr0 == PW'(g))      mem[g] <= w0_byte;
            else if (n_wr == 2'd2 && wr1 == PW'(g)) mem[g] <= in_b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd    <= '0;
            level <= '0;
        end else begin
            if (stored_pop) rd <= wrap((PW+1)'(rd) + (PW+1)'(1));
            level <= level + LW'(n_wr) - LW'(stored_pop);
        end
    end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import prefetch_q_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int AW = 20,
    parameter logic [AW-1:0] RESET_ADDR = 'hFFFF0,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int FETCH_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_accept,
    input  logic          fetch_valid,
    input  logic [15:0]   fetch_data,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          take,
    input  logic          take_first,
    output logic          byte_valid,
    output logic [7:0]    byte_out,
    output logic [1:0]    q_status
);

    logic [LW-1:0] level;
    logic          room_ok, land, land_odd, popped;
    logic [1:0]    in_cnt;
    logic [7:0]    in_b0;
    qstat_t        qs_q;

    assign room_ok = level <= LW'(DEPTH - FETCH_BYTES);
    assign in_cnt  = land ? (land_odd ? 2'd1 : 2'd2) : 2'd0;
    assign in_b0   = land_odd ? fetch_data[15:8] : fetch_data[7:0];

    prefetch_fetch_ctl #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
        .clk(clk), .rst_n(rst_n), .room_ok(room_ok), .flush(flush),
        .flush_addr(flush_addr), .fetch_accept(fetch_accept),
        .fetch_valid(fetch_valid), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .land(land), .land_odd(land_odd)
    );

    prefetch_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .clear(flush), .in_cnt(in_cnt),
        .in_b0(in_b0), .in_b1(fetch_data[15:8]), .take(take),
        .out_valid(byte_valid), .out_byte(byte_out), .popped(popped),
        .level(level)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      qs_q <= QS_NONE;
        else if (flush)  qs_q <= QS_FLUSHED;
        else if (popped) qs_q <= take_first ? QS_FIRST : QS_NEXT;
        else             qs_q <= QS_NONE;
    end

    assign q_status = qs_q;

endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
    parameter int DEPTH = 6,
    parameter int AW = 20,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_req,
    input logic          fetch_accept,
    input logic [AW-1:0] fetch_addr,
    input logic          flush,
    input logic          take,
    input logic          take_first,
    input logic          byte_valid,
    input logic [1:0]    q_status,
    input logic [LW-1:0] level
);

    assert_one_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_accept |=> !fetch_req);

    assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    assert_req_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (level <= LW'(DEPTH - 2)) && !flush);

    assert_flush_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> q_status == 2'b10);

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !byte_valid);

    assert_first_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take && take_first && byte_valid && !flush |=> q_status == 2'b01);

    assert_quiet_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && !(take && byte_valid) |=> q_status == 2'b00);

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_accept |=> $stable(fetch_addr));

endmodule

bind prefetch_queue prefetch_queue_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
    .fetch_accept(fetch_accept), .fetch_addr(fetch_addr), .flush(flush),
    .take(take), .take_first(take_first), .byte_valid(byte_valid),
    .q_status(q_status), .level(level)
);

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;

    localparam logic [19:0] RST_A = 20'hFFFF0;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        fetch_req, fetch_accept = 0, fetch_valid = 0;
    logic [19:0] fetch_addr, flush_addr = '0;
    logic [15:0] fetch_data = '0;
    logic        flush = 0, take = 0, take_first = 0;
    logic        byte_valid;
    logic [7:0]  byte_out;
    logic [1:0]  q_status;

    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prefetch_queue u_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_accept(fetch_accept), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .flush(flush), .flush_addr(flush_addr),
        .take(take), .take_first(take_first), .byte_valid(byte_valid),
        .byte_out(byte_out), .q_status(q_status)
    );

    // reference model state: 0 idle, 1 waiting, 2 dropping
    logic [7:0]  mq[$];
    int          m_st;
    logic [19:0] m_addr;
    logic [1:0]  m_qs;
    // bus model
    bit          b_pend;
    int          b_cnt;
    logic [19:0] b_addr;
    logic [31:0] rnd = 32'h1234_5678;

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h3, a[19:16]};
    endfunction

    task automatic step_rnd();
        rnd = rnd ^ (rnd << 13);
        rnd = rnd ^ (rnd >> 17);
        rnd = rnd ^ (rnd << 5);
    endtask

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        bit e_req, e_bv, odd;
        logic [7:0] e_b;
        odd   = m_addr[0];
        e_req = (m_st == 0) && (mq.size() <= 4) && !flush;
        e_bv  = (mq.size() > 0) || (m_st == 1 && fetch_valid && !flush);
        e_b   = (mq.size() > 0) ? mq[0] : (odd ? fetch_data[15:8] : fetch_data[7:0]);
        chk(fetch_req == e_req, {tag, " R2 R9 fetch_req"}, 32'(fetch_req), 32'(e_req));
        chk(fetch_addr == m_addr, {tag, " R7 fetch_addr"}, 32'(fetch_addr), 32'(m_addr));
        chk(byte_valid == e_bv, {tag, " R4 R6 R8 byte_valid"}, 32'(byte_valid), 32'(e_bv));
        if (e_bv)
            chk(byte_out == e_b, {tag, " R3 R4 byte_out"}, 32'(byte_out), 32'(e_b));
        chk(q_status == m_qs, {tag, " R5 R10 q_status"}, 32'(q_status), 32'(m_qs));
    endtask

    task automatic model_update();
        bit e_req, e_bv;
        e_req = (m_st == 0) && (mq.size() <= 4) && !flush;
        e_bv  = (mq.size() > 0) || (m_st == 1 && fetch_valid && !flush);
        if (flush) begin
            mq.delete();
            m_addr = flush_addr;
            if (m_st == 1 && !fetch_valid) m_st = 2;
            else if (fetch_valid)          m_st = 0;
            m_qs = 2'b10;
        end else begin
            if (m_st == 1 && fetch_valid) begin
                if (m_addr[0]) begin
                    mq.push_back(fetch_data[15:8]);
                    m_addr = m_addr + 20'd1;
                end else begin
                    mq.push_back(fetch_data[7:0]);
                    mq.push_back(fetch_data[15:8]);
                    m_addr = m_addr + 20'd2;
                end
                m_st = 0;
            end else if (m_st == 2 && fetch_valid) m_st = 0;
            if (take && e_bv) begin
                void'(mq.pop_front());
                m_qs = take_first ? 2'b01 : 2'b11;
            end else m_qs = 2'b00;
            if (e_req && fetch_accept) m_st = 1;
        end
        // bus side
        if (fetch_valid) b_pend = 0;
        else if (b_pend && b_cnt > 0) b_cnt--;
        if (e_req && fetch_accept) begin
            b_pend = 1;
            b_addr = m_addr;
            b_cnt  = int'(rnd[9:8]) % 3;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [19:0] wa;
        mq.delete(); m_st = 0; m_addr = RST_A; m_qs = 2'b00;
        b_pend = 0; b_cnt = 0; b_addr = '0;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1 compare("R1 reset");
        end
        rst_n = 1;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            step_rnd();
            fetch_accept = rnd[0] | rnd[1];
            fetch_valid  = b_pend && (b_cnt == 0);
            wa           = {b_addr[19:1], 1'b0};
            fetch_data   = fetch_valid ? {mbyte(wa | 20'd1), mbyte(wa)} : 16'h0;
            take         = (i >= 30) && (rnd[4:3] != 2'b00);
            take_first   = rnd[5];
            flush        = (i == 60) || (i == 100) || (i == 140) ||
                           (i >= 200 && rnd[12:10] == 3'd0);
            flush_addr   = (i == 60) ? 20'h00101 : (i == 100 ? 20'h02000 : rnd[31:12]);
            if (i == 100) take = 1;
            #1 compare($sformatf("cyc%0d", i));
            model_update();
        end
        @(negedge clk);
        flush = 0; take = 0; fetch_accept = 0; fetch_valid = 0;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule